// File: doc/BRIEF.md
# Receiver Bring-Up Sequencer

This block is the control state machine that brings a serial transceiver's receiver into service. The receiver runs with analog clock recovery and with its elastic buffer bypassed. The machine drives the PMA reset, then waits for clock-recovery lock. It then drives the receive reset and issues a phase-alignment pulse. Finally it watches a burst-error flag until the link has stayed clean for a full window, and at that point it raises link-ready.

The recovered user clocks may stop while the transceiver is in reset, so the sequencer runs on a free-running system clock. Every wait is given as a count of slow user-clock cycles. A package function turns that count into system-clock cycles, using the integer parameter `SYS_PER_USR`, which is the number of system cycles per user cycle, rounded up.

There is no separate alignment-error input. A failed phase alignment shows up as errors on the same error flag. Each error seen while lock is held counts as one sync attempt and triggers a new phase-alignment pulse. When the count reaches `MAX_SYNC`, the machine goes back to the PMA reset instead. Losing lock after the lock wait also sends the machine back to the PMA reset.

Top module: `rx_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `pma_rst` is 1 and `rx_rst`, `phase_sync` and `link_ready` are 0.
- R2: `pma_rst` stays high for at least `PMA_RST_USR*SYS_PER_USR` system cycles, and it stays high for as long as `usr_clk_stable` is 0. Once both conditions are met, `pma_rst` falls on the next clock edge.
- R3: After `pma_rst` falls, all four outputs stay low for exactly `LOCK_WAIT_USR*SYS_PER_USR` cycles. If `cdr_lock` is then 1, `rx_rst` rises. If it is 0, `pma_rst` rises again.
- R4: `rx_rst` stays high for exactly `RX_RST_USR*SYS_PER_USR` cycles. `phase_sync` then rises in the very next cycle and stays high for exactly one cycle.
- R5: With `cdr_lock` held and no counted error, `link_ready` rises exactly `(SYNC_WAIT_USR+MONITOR_USR)*SYS_PER_USR` cycles after `phase_sync` falls. `link_ready` stays high until an error or a loss of lock.
- R6: During the error-free window or while `link_ready` is high, a clock edge with both `rx_err` and `cdr_lock` at 1 counts one sync attempt. In the next cycle `phase_sync` pulses and `link_ready` is 0.
- R7: `rx_err` has no effect in any other state. In particular, an error during the post-sync wait neither adds a `phase_sync` pulse nor delays `link_ready`.
- R8: When a counted error brings the attempt total to `MAX_SYNC`, `pma_rst` rises in the next cycle in place of a `phase_sync` pulse.
- R9: The attempt count is zero after any cycle spent in PMA reset. After a restart, a single error therefore produces a `phase_sync` pulse and not a PMA reset.
- R10: If `cdr_lock` is 0 at a clock edge anywhere from the receive reset through link-ready, `pma_rst` is 1 in the next cycle.
- R11: At most one of `pma_rst`, `rx_rst`, `phase_sync` and `link_ready` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_clk_stable | input | 1 | High when both receive user clocks are stable |
| cdr_lock | input | 1 | Clock-recovery lock flag from the transceiver |
| rx_err | input | 1 | Burst of disparity or invalid-code errors on received data |
| pma_rst | output | 1 | PMA reset to the transceiver |
| rx_rst | output | 1 | Receive datapath reset |
| phase_sync | output | 1 | One-cycle phase-alignment request |
| link_ready | output | 1 | Receive link usable |

## Verification
The properties assume that `usr_clk_stable`, `cdr_lock` and `rx_err` are already synchronous to the system clock, since each is sampled once per edge with no filtering. They also assume that `rx_err` is only meaningful while lock is held. The bench changes every input on the falling edge, so each input holds a single value for a whole rising-edge sample. Error pulses are one cycle wide and are placed at computed offsets inside a chosen state. The state boundaries then fall at cycle counts the bench derives from the shortened parameters.

// File: rtl/rxbs_pkg.sv
package rxbs_pkg;

  typedef enum logic [2:0] {
    ST_PMA_RST    = 3'd0,
    ST_WAIT_LOCK  = 3'd1,
    ST_RX_RST     = 3'd2,
    ST_PHASE_SYNC = 3'd3,
    ST_WAIT_SYNC  = 3'd4,
    ST_MONITOR    = 3'd5,
    ST_READY      = 3'd6
  } rxbs_state_e;

  // Wait length in system cycles for a count of slow user-clock cycles.
  function automatic int unsigned usr_to_sys(input int unsigned usr_cycles,
                                             input int unsigned sys_per_usr);
    int unsigned prod;
    prod = usr_cycles * sys_per_usr;
    return (prod == 0) ? 1 : prod;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rxbs_timer.sv
module rxbs_timer #(
  parameter int unsigned TW      = 8,
  parameter logic [TW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt_q;

  // A load of N makes the new state last exactly N cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= RST_VAL;
    else if (load)            cnt_q <= load_val - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/rxbs_attempt_ctr.sv
module rxbs_attempt_ctr #(
  parameter int unsigned MAX_SYNC = 4,
  parameter int unsigned AW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bump,
  output logic [AW-1:0] count,
  output logic          at_limit
);

  localparam logic [AW-1:0] LIMIT_M1 = AW'(MAX_SYNC - 1);
  localparam logic [AW-1:0] LIMIT    = AW'(MAX_SYNC);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clear)                    cnt_q <= '0;
    else if (bump && cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  assign count    = cnt_q;
  // The next counted error would reach the limit.
  assign at_limit = (cnt_q >= LIMIT_M1);

endmodule

// File: rtl/rxbs_fsm.sv
module rxbs_fsm
  import rxbs_pkg::*;
#(
  parameter int unsigned TW     = 8,
  parameter int unsigned T_PMA  = 8,
  parameter int unsigned T_LOCK = 8,
  parameter int unsigned T_RXR  = 8,
  parameter int unsigned T_SYNC = 8,
  parameter int unsigned T_MON  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usr_clk_stable,
  input  logic          cdr_lock,
  input  logic          rx_err,
  input  logic          timer_done,
  input  logic          at_limit,
  output rxbs_state_e   state,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          bump,
  output logic          lock_drop,
  output logic          retry_evt,
  output logic          escalate_evt
);

  localparam logic [TW-1:0] L_PMA  = TW'(T_PMA);
  localparam logic [TW-1:0] L_LOCK = TW'(T_LOCK);
  localparam logic [TW-1:0] L_RXR  = TW'(T_RXR);
  localparam logic [TW-1:0] L_SYNC = TW'(T_SYNC);
  localparam logic [TW-1:0] L_MON  = TW'(T_MON);
  localparam logic [TW-1:0] L_ONE  = TW'(1);

  rxbs_state_e st_q, st_d;
  logic        locked_state, err_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PMA_RST;
    else        st_q <= st_d;
  end

  always_comb begin
    locked_state = (st_q == ST_RX_RST) || (st_q == ST_PHASE_SYNC) ||
                   (st_q == ST_WAIT_SYNC) || (st_q == ST_MONITOR) ||
                   (st_q == ST_READY);
    err_seen     = rx_err && cdr_lock &&
                   ((st_q == ST_MONITOR) || (st_q == ST_READY));
  end

  always_comb begin
    st_d         = st_q;
    lock_drop    = 1'b0;
    bump         = 1'b0;
    retry_evt    = 1'b0;
    escalate_evt = 1'b0;
    if (locked_state && !cdr_lock) begin
      lock_drop = 1'b1;
      st_d      = ST_PMA_RST;
    end else if (err_seen) begin
      bump = 1'b1;
      if (at_limit) begin
        escalate_evt = 1'b1;
        st_d         = ST_PMA_RST;
      end else begin
        retry_evt = 1'b1;
        st_d      = ST_PHASE_SYNC;
      end
    end else begin
      case (st_q)
        ST_PMA_RST:    if (timer_done && usr_clk_stable) st_d = ST_WAIT_LOCK;
        ST_WAIT_LOCK:  if (timer_done) st_d = cdr_lock ? ST_RX_RST : ST_PMA_RST;
        ST_RX_RST:     if (timer_done) st_d = ST_PHASE_SYNC;
        ST_PHASE_SYNC: st_d = ST_WAIT_SYNC;
        ST_WAIT_SYNC:  if (timer_done) st_d = ST_MONITOR;
        ST_MONITOR:    if (timer_done) st_d = ST_READY;
        default:       st_d = st_q;
      endcase
    end
  end

  // Reload the timer on every state change with the new state's length.
  always_comb begin
    tmr_load = (st_d != st_q);
    case (st_d)
      ST_PMA_RST:   tmr_val = L_PMA;
      ST_WAIT_LOCK: tmr_val = L_LOCK;
      ST_RX_RST:    tmr_val = L_RXR;
      ST_WAIT_SYNC: tmr_val = L_SYNC;
      ST_MONITOR:   tmr_val = L_MON;
      default:      tmr_val = L_ONE;
    endcase
  end

  assign state = st_q;

endmodule

// File: rtl/rx_bringup_seq.sv
module rx_bringup_seq
  import rxbs_pkg::*;
#(
  parameter int unsigned SYS_PER_USR   = 2,
  parameter int unsigned PMA_RST_USR   = 4,
  parameter int unsigned LOCK_WAIT_USR = 16384,
  parameter int unsigned RX_RST_USR    = 4,
  parameter int unsigned SYNC_WAIT_USR = 64,
  parameter int unsigned MONITOR_USR   = 1024,
  parameter int unsigned MAX_SYNC      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic usr_clk_stable,
  input  logic cdr_lock,
  input  logic rx_err,
  output logic pma_rst,
  output logic rx_rst,
  output logic phase_sync,
  output logic link_ready
);

  localparam int unsigned T_PMA  = usr_to_sys(PMA_RST_USR,   SYS_PER_USR);
  localparam int unsigned T_LOCK = usr_to_sys(LOCK_WAIT_USR, SYS_PER_USR);
  localparam int unsigned T_RXR  = usr_to_sys(RX_RST_USR,    SYS_PER_USR);
  localparam int unsigned T_SYNC = usr_to_sys(SYNC_WAIT_USR, SYS_PER_USR);
  localparam int unsigned T_MON  = usr_to_sys(MONITOR_USR,   SYS_PER_USR);
  localparam int unsigned T_MAX  = max2(max2(T_PMA, T_LOCK), max2(max2(T_RXR, T_SYNC), T_MON));
  localparam int unsigned TW     = bits_for(T_MAX);
  localparam int unsigned AW     = bits_for(MAX_SYNC);
  localparam logic [TW-1:0] TMR_RST = TW'(T_PMA - 1);

  rxbs_state_e   state;
  logic          tmr_load, timer_done, bump, at_limit;
  logic [TW-1:0] tmr_val;
  logic [AW-1:0] attempt_cnt;
  logic          lock_drop, retry_evt, escalate_evt;

  rxbs_fsm #(
    .TW(TW), .T_PMA(T_PMA), .T_LOCK(T_LOCK), .T_RXR(T_RXR),
    .T_SYNC(T_SYNC), .T_MON(T_MON)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .usr_clk_stable(usr_clk_stable),
    .cdr_lock(cdr_lock), .rx_err(rx_err), .timer_done(timer_done),
    .at_limit(at_limit), .state(state), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .bump(bump), .lock_drop(lock_drop),
    .retry_evt(retry_evt), .escalate_evt(escalate_evt)
  );

  rxbs_timer #(.TW(TW), .RST_VAL(TMR_RST)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .done(timer_done)
  );

  rxbs_attempt_ctr #(.MAX_SYNC(MAX_SYNC), .AW(AW)) u_attempts (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_PMA_RST), .bump(bump),
    .count(attempt_cnt), .at_limit(at_limit)
  );

  assign pma_rst    = (state == ST_PMA_RST);
  assign rx_rst     = (state == ST_RX_RST);
  assign phase_sync = (state == ST_PHASE_SYNC);
  assign link_ready = (state == ST_READY);

endmodule

// File: rtl/rxbs_checker.sv
module rxbs_checker
  import rxbs_pkg::*;
#(
  parameter int unsigned MAX_SYNC = 4,
  localparam int unsigned AW = bits_for(MAX_SYNC)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          usr_clk_stable,
  input logic          cdr_lock,
  input logic          rx_err,
  input logic          pma_rst,
  input logic          rx_rst,
  input logic          phase_sync,
  input logic          link_ready,
  input logic          lock_drop,
  input logic          retry_evt,
  input logic          escalate_evt,
  input logic [AW-1:0] attempt_cnt
);

  // R11
  a_r11_one_hot_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pma_rst, rx_rst, phase_sync, link_ready}));

  // R4
  a_r4_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    phase_sync |=> !phase_sync);

  // R4: receive reset ends in a sync pulse unless lock was lost
  a_r4_rx_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_rst) |-> (phase_sync || pma_rst));

  // R2
  a_r2_hold_unstable: assert property (@(posedge clk) disable iff (!rst_n)
    (pma_rst && !usr_clk_stable) |=> pma_rst);

  // R10
  a_r10_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
    lock_drop |=> pma_rst);

  // R6
  a_r6_retry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    retry_evt |=> phase_sync);

  // R6
  a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready && rx_err && cdr_lock) |=> !link_ready);

  // R8
  a_r8_escalate: assert property (@(posedge clk) disable iff (!rst_n)
    escalate_evt |=> pma_rst);

  // R9
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pma_rst |=> (attempt_cnt == '0));

endmodule

bind rx_bringup_seq rxbs_checker #(.MAX_SYNC(MAX_SYNC)) u_chk (
  .clk(clk), .rst_n(rst_n), .usr_clk_stable(usr_clk_stable),
  .cdr_lock(cdr_lock), .rx_err(rx_err), .pma_rst(pma_rst),
  .rx_rst(rx_rst), .phase_sync(phase_sync), .link_ready(link_ready),
  .lock_drop(lock_drop), .retry_evt(retry_evt),
  .escalate_evt(escalate_evt), .attempt_cnt(attempt_cnt)
);

// File: tb/rx_bringup_seq_tb_top.sv
module rx_bringup_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RATIO  = 2;
  localparam int P_USR  = 3;
  localparam int L_USR  = 5;
  localparam int R_USR  = 2;
  localparam int S_USR  = 4;
  localparam int M_USR  = 6;
  localparam int MAXS   = 3;
  localparam int E_PMA  = P_USR * RATIO;
  localparam int E_LOCK = L_USR * RATIO;
  localparam int E_RXR  = R_USR * RATIO;
  localparam int E_POST = (S_USR + M_USR) * RATIO;

  logic clk = 1'b0;
  logic rst_n, usr_clk_stable, cdr_lock, rx_err;
  logic pma_rst, rx_rst, phase_sync, link_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_bringup_seq #(
    .SYS_PER_USR(RATIO), .PMA_RST_USR(P_USR), .LOCK_WAIT_USR(L_USR),
    .RX_RST_USR(R_USR), .SYNC_WAIT_USR(S_USR), .MONITOR_USR(M_USR),
    .MAX_SYNC(MAXS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .usr_clk_stable(usr_clk_stable),
    .cdr_lock(cdr_lock), .rx_err(rx_err), .pma_rst(pma_rst),
    .rx_rst(rx_rst), .phase_sync(phase_sync), .link_ready(link_ready)
  );

  // Output index: 0 pma_rst, 1 rx_rst, 2 phase_sync, 3 link_ready
  logic [3:0] obs, prev;
  assign obs = {link_ready, phase_sync, rx_rst, pma_rst};

  int ncyc = 0;
  int rise_t[4], fall_t[4], rise_n[4];
  int multi_hot = 0;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  initial begin
    prev = '0;
    for (int i = 0; i < 4; i++) begin rise_t[i] = 0; fall_t[i] = 0; rise_n[i] = 0; end
  end

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(negedge clk) begin
    for (int w = 0; w < 4; w++) begin
      if (obs[w] && !prev[w]) begin rise_t[w] = ncyc; rise_n[w] = rise_n[w] + 1; end
      if (!obs[w] && prev[w]) fall_t[w] = ncyc;
    end
    if ($countones(obs) > 1) multi_hot = multi_hot + 1;
    prev = obs;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(input string req, input int w, input int base, input int limit);
    int k = 0;
    while (rise_n[w] == base && k < limit) begin @(posedge clk); k++; end
    if (rise_n[w] == base) begin
      n_chk++; n_err++;
      $display("FAIL %s: actual no rise on output %0d expected a rise within %0d cycles", req, w, limit);
    end
  endtask

  task automatic wait_to(input int t);
    do @(negedge clk); while (ncyc < t);
  endtask

  task automatic pulse_err();
    rx_err = 1'b1;
    @(negedge clk);
    rx_err = 1'b0;
  endtask

  initial begin
    int t, f, b0, b2, b3;
    rst_n = 1'b0; usr_clk_stable = 1'b0; cdr_lock = 1'b0; rx_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", int'(obs), 1);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R2 held while clocks unstable", int'(pma_rst), 1);

    // First bring-up
    t = ncyc; b3 = rise_n[3];
    usr_clk_stable = 1'b1; cdr_lock = 1'b1;
    wait_rise("R5 first ready", 3, b3, 300);
    chk("R2 release after stable", fall_t[0] - t, 1);
    chk("R3 lock wait length", rise_t[1] - fall_t[0], E_LOCK);
    chk("R4 rx reset width", fall_t[1] - rise_t[1], E_RXR);
    chk("R4 sync follows rx reset", rise_t[2] - fall_t[1], 0);
    chk("R4 sync width", fall_t[2] - rise_t[2], 1);
    chk("R5 sync to ready", rise_t[3] - fall_t[2], E_POST);

    // Attempt 1: error while ready
    wait_to(ncyc + 3);
    t = ncyc; b2 = rise_n[2]; b3 = rise_n[3];
    pulse_err();
    wait_to(t + 3);
    chk("R6 sync after ready error", rise_t[2] - t, 1);
    chk("R6 ready drops", fall_t[3] - t, 1);

    // Ignored error during post-sync wait, then attempt 2 in monitor window
    f = fall_t[2];
    b2 = rise_n[2];
    wait_to(f + 3);
    pulse_err();
    wait_to(f + 12);
    pulse_err();
    wait_to(f + 15);
    chk("R7 error in sync wait ignored", rise_n[2] - b2, 1);
    chk("R6 monitor error resyncs", rise_t[2], f + 13);

    wait_rise("R5 ready after retry", 3, b3, 300);
    chk("R5 ready after retry", rise_t[3] - fall_t[2], E_POST);

    // Attempt 3 reaches the limit
    wait_to(ncyc + 2);
    t = ncyc; b2 = rise_n[2]; b3 = rise_n[3];
    pulse_err();
    wait_to(t + 3);
    chk("R8 escalation to pma reset", rise_t[0] - t, 1);
    chk("R8 no sync pulse on escalation", rise_n[2] - b2, 0);

    // Restart: minimum reset width, then count must be clear
    wait_rise("R9 ready after restart", 3, b3, 300);
    chk("R2 minimum pma reset width", fall_t[0] - rise_t[0], E_PMA);
    wait_to(ncyc + 2);
    t = ncyc; b0 = rise_n[0];
    pulse_err();
    wait_to(t + 3);
    chk("R9 single error resyncs after clear", rise_t[2] - t, 1);
    chk("R9 no pma reset after clear", rise_n[0] - b0, 0);

    // Lock loss during post-sync wait
    wait_to(t + 4);
    t = ncyc; b0 = rise_n[0];
    cdr_lock = 1'b0;
    wait_to(t + 2);
    chk("R10 lock loss in sync wait", rise_t[0] - t, 1);

    // Lock still missing at end of lock wait
    b0 = rise_n[0];
    wait_rise("R3 retry on no lock", 0, b0, 200);
    chk("R3 no lock returns to pma reset", rise_t[0] - fall_t[0], E_LOCK);

    // Recover, then lose lock while ready
    @(negedge clk);
    cdr_lock = 1'b1; b3 = rise_n[3];
    wait_rise("R10 ready before lock loss", 3, b3, 300);
    wait_to(ncyc + 2);
    t = ncyc;
    cdr_lock = 1'b0;
    wait_to(t + 2);
    chk("R10 lock loss in ready", rise_t[0] - t, 1);
    chk("R10 ready drops on lock loss", fall_t[3] - t, 1);

    chk("R11 outputs mutually exclusive", multi_hot, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): actual 20000 cycles expected completion earlier");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule